// File: doc/BRIEF.md
# Registered Command Buffer with Chip-Select Modes

This block sits between a memory controller and the DRAM devices of a module. On every rising clock edge it captures a command/address bus, the chip-select lines and the clock-enable and termination controls, and drives them out one clock later. The command/address bus leaves as two identical copies, an A side and a B side, so that each copy drives half of the devices.

A static strap input chooses how the chip selects are arranged. With the strap high, two chip-select inputs are each sent to an A-side copy and a B-side copy. With the strap low, four chip-select inputs map straight onto four outputs. In that mode the two top command/address bits feed only their A-side outputs, and the B-side copies of those bits are parked low.

When both registered clock enables are low, the devices are in power-down. The command/address outputs then stop following their inputs and hold their last values. The chip-select, clock-enable and termination outputs keep updating. A synchronous active-low reset puts every output into a defined idle state.

Top module: `regcmd_buffer`

## Requirements
- R1: With `csModeDual`=1, `csOutN[0]` and `csOutN[2]` take `csInN[0]`, and `csOutN[1]` and `csOutN[3]` take `csInN[1]`, one clock after capture.
- R2: With `csModeDual`=1, the values of `csInN[3]` and `csInN[2]` have no effect on any output.
- R3: With `csModeDual`=0, `csOutN[i]` takes `csInN[i]` for i = 0..3, one clock after capture.
- R4: Outside power-down, `caOutA` equals the `caIn` value captured one clock earlier. In dual mode `caOutB` carries the same value.
- R5: With `csModeDual`=0, bits CA_W-1 and CA_W-2 of `caOutB` are driven 0 one clock after capture, whatever the power state. The same bits of `caOutA` still carry their inputs.
- R6: `ckeOut` and `odtOut` equal `ckeIn` and `odtIn` from one clock earlier, in all modes and power states.
- R7: At an edge where the registered `ckeOut` is 2'b00, `caOutA` and the shared bits of `caOutB` keep their values. The chip-select outputs keep updating.
- R8: While `rstN` is low at an edge, the outputs become `caOutA`=0, `caOutB`=0, `csOutN`=4'b1111, `ckeOut`=0 and `odtOut`=0.
- R9: After power-down, the command/address outputs update again first at the edge that follows the edge that captured a nonzero `ckeIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock; rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| csModeDual | input | 1 | Strap: 1 = two chip selects with two copies each, 0 = four chip selects mapped 1:1 |
| caIn | input | CA_W | Command/address input bus |
| csInN | input | 4 | Chip-select inputs, active low |
| ckeIn | input | 2 | Clock-enable inputs |
| odtIn | input | 2 | On-die termination inputs |
| caOutA | output | CA_W | Command/address copy A |
| caOutB | output | CA_W | Command/address copy B |
| csOutN | output | 4 | Chip-select outputs, active low |
| ckeOut | output | 2 | Registered clock enables |
| odtOut | output | 2 | Registered termination controls |

## Verification
Chip-select, clock-enable and termination results are due exactly one edge after their inputs are captured. Command/address results are due one edge after capture, but only when the clock enable registered at the previous edge was nonzero. This puts the resume point after power-down one edge later than the first high clock-enable input. The bench drives inputs on the falling edge and advances a behavioural model by one edge at that moment. It compares every output on the next falling edge. The model therefore carries exactly the one-edge latency and the delayed power-down gate without sampling at the active edge.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic caLoad;    // command/address registers may update
    logic quadMode;  // four chip-select arrangement active
  } ctlStrobes_t;

  localparam int unsigned CS_COUNT   = 4;
  localparam int unsigned SWAP_BITS  = 2;  // top CA bits that become 1:1 in quad mode
endpackage

// File: rtl/regcmd_ctl.sv
module regcmd_ctl
  import regcmd_pkg::*;
#(
  parameter int unsigned CKE_W = 2,
  parameter int unsigned ODT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csModeDual,
  input  logic [CKE_W-1:0] ckeIn,
  input  logic [ODT_W-1:0] odtIn,
  output logic [CKE_W-1:0] ckeOut,
  output logic [ODT_W-1:0] odtOut,
  output ctlStrobes_t      strobes
);

  logic [CKE_W-1:0] ckeQ;
  logic [ODT_W-1:0] odtQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckeQ <= '0;
      odtQ <= '0;
    end else begin
      ckeQ <= ckeIn;
      odtQ <= odtIn;
    end
  end

  // Power-down is decided on the registered enables
  always_comb begin
    strobes.caLoad   = |ckeQ;
    strobes.quadMode = ~csModeDual;
  end

  assign ckeOut = ckeQ;
  assign odtOut = odtQ;

  p_ctl_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (ckeOut == $past(ckeIn)) && (odtOut == $past(odtIn)));

  p_reset_idle_r8: assert property (@(posedge clk)
    $past(rstN) == 1'b0 && $past(rstN, 2) == 1'b1 |-> ckeOut == '0 && odtOut == '0);

endmodule

// File: rtl/regcmd_datapath.sv
module regcmd_datapath
  import regcmd_pkg::*;
#(
  parameter int unsigned CA_W = 22
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [CA_W-1:0]     caIn,
  input  logic [CS_COUNT-1:0] csInN,
  output logic [CA_W-1:0]     caOutA,
  output logic [CA_W-1:0]     caOutB,
  output logic [CS_COUNT-1:0] csOutN
);

  localparam int unsigned PLAIN_BITS = CA_W - SWAP_BITS;
  localparam int unsigned DUAL_SRC   = CS_COUNT / 2;
  localparam logic [CA_W-1:0] SHARED_MASK =
    {{SWAP_BITS{1'b1}}, {PLAIN_BITS{1'b0}}};

  logic [CA_W-1:0]     caAQ, caBQ, caANext, caBNext;
  logic [CS_COUNT-1:0] csQ, csNext;

  // Chip-select routing: dual mode folds the upper outputs onto the lower inputs
  for (genvar i = 0; i < CS_COUNT; i++) begin : g_csRoute
    localparam int unsigned DUAL_IDX = i % DUAL_SRC;
    assign csNext[i] = strobes.quadMode ? csInN[i] : csInN[DUAL_IDX];
  end

  always_comb begin
    caANext = strobes.caLoad ? caIn : caAQ;
    caBNext = strobes.caLoad ? caIn : caBQ;
    if (strobes.quadMode) caBNext = caBNext & ~SHARED_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      caAQ <= '0;
      caBQ <= '0;
      csQ  <= '1;
    end else begin
      caAQ <= caANext;
      caBQ <= caBNext;
      csQ  <= csNext;
    end
  end

  assign caOutA = caAQ;
  assign caOutB = caBQ;
  assign csOutN = csQ;

  p_dual_copies_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(strobes.quadMode) |->
      csOutN[2] == $past(csInN[0]) && csOutN[3] == $past(csInN[1]) &&
      csOutN[0] == $past(csInN[0]) && csOutN[1] == $past(csInN[1]));

  p_quad_direct_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strobes.quadMode) |-> csOutN == $past(csInN));

  p_load_copy_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strobes.caLoad) |-> caOutA == $past(caIn));

  p_parked_b_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strobes.quadMode) |-> caOutB[CA_W-1 -: SWAP_BITS] == '0);

  p_hold_static_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.caLoad |=> $stable(caOutA));

endmodule

// File: rtl/regcmd_buffer.sv
module regcmd_buffer
  import regcmd_pkg::*;
#(
  parameter int unsigned CA_W = 22
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csModeDual,
  input  logic [CA_W-1:0] caIn,
  input  logic [3:0]      csInN,
  input  logic [1:0]      ckeIn,
  input  logic [1:0]      odtIn,
  output logic [CA_W-1:0] caOutA,
  output logic [CA_W-1:0] caOutB,
  output logic [3:0]      csOutN,
  output logic [1:0]      ckeOut,
  output logic [1:0]      odtOut
);

  ctlStrobes_t strobes;

  regcmd_ctl #(.CKE_W(2), .ODT_W(2)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .csModeDual (csModeDual),
    .ckeIn      (ckeIn),
    .odtIn      (odtIn),
    .ckeOut     (ckeOut),
    .odtOut     (odtOut),
    .strobes    (strobes)
  );

  regcmd_datapath #(.CA_W(CA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .caIn    (caIn),
    .csInN   (csInN),
    .caOutA  (caOutA),
    .caOutB  (caOutB),
    .csOutN  (csOutN)
  );

endmodule

// File: tb/tb_regcmd_buffer.sv
`timescale 1ns/1ps
module tb_regcmd_buffer;
  localparam int CA_W = 22;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            csModeDual = 1'b1;
  logic [CA_W-1:0] caIn = '0;
  logic [3:0]      csInN = 4'hF;
  logic [1:0]      ckeIn = '0;
  logic [1:0]      odtIn = '0;
  logic [CA_W-1:0] caOutA, caOutB;
  logic [3:0]      csOutN;
  logic [1:0]      ckeOut, odtOut;

  regcmd_buffer #(.CA_W(CA_W)) dut (.*);

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // Behavioural model state
  logic [CA_W-1:0] eA = '0, eB = '0;
  logic [3:0]      eCs = 4'hF;
  logic [1:0]      eCke = '0, eOdt = '0;
  string tagCs = "R8", tagA = "R8", tagB = "R8", tagCtl = "R8";
  bit wasHeld = 1;

  task automatic chk(input string tag, input string what,
                     input logic [CA_W-1:0] act, input logic [CA_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Advance the model by one edge using inputs as they will be captured
  task automatic model_step();
    bit ld;
    if (!rstN) begin
      eA = '0; eB = '0; eCs = 4'hF; eCke = '0; eOdt = '0;
      tagCs = "R8"; tagA = "R8"; tagB = "R8"; tagCtl = "R8";
      wasHeld = 1;
      return;
    end
    ld = (eCke != 2'b00);
    if (ld) begin
      eA = caIn; eB = caIn;
      tagA = wasHeld ? "R9" : "R4";
    end else begin
      tagA = "R7";
    end
    wasHeld = !ld;
    if (!csModeDual) begin
      eB[CA_W-1 -: 2] = 2'b00;
      tagB = "R5";
    end else tagB = tagA;
    if (csModeDual) begin
      eCs = {csInN[1], csInN[0], csInN[1], csInN[0]};
      tagCs = ld ? "R1,R2" : "R7,R1";
    end else begin
      eCs = csInN;
      tagCs = "R3";
    end
    eCke = ckeIn; eOdt = odtIn;
    tagCtl = "R6";
  endtask

  task automatic compare_all();
    chk(tagA, "caOutA", caOutA, eA);
    chk(tagB, "caOutB", caOutB, eB);
    chk(tagCs, "csOutN", CA_W'(csOutN), CA_W'(eCs));
    chk(tagCtl, "ckeOut", CA_W'(ckeOut), CA_W'(eCke));
    chk(tagCtl, "odtOut", CA_W'(odtOut), CA_W'(eOdt));
  endtask

  // One cycle: check at falling edge, drive new inputs, step model
  task automatic cycle(input bit r, input bit dual, input logic [1:0] cke);
    @(negedge clk);
    compare_all();
    rstN = r;
    csModeDual = dual;
    caIn = CA_W'($urandom);
    csInN = 4'($urandom);
    ckeIn = cke;
    odtIn = 2'($urandom);
    model_step();
  endtask

  initial begin
    model_step();
    for (int i = 0; i < 3; i++) cycle(0, 1, 2'b11);           // R8 reset
    for (int i = 0; i < 40; i++) cycle(1, 1, 2'($urandom) | 2'b01); // R1 R2 R4 R9
    for (int i = 0; i < 12; i++) cycle(1, 1, 2'b00);          // R7 power-down
    cycle(1, 1, 2'b10);                                       // R9 exit
    for (int i = 0; i < 20; i++) cycle(1, 1, 2'($urandom));   // R6 mixed enables
    for (int i = 0; i < 40; i++) cycle(1, 0, 2'b11);          // R3 R5 quad mode
    for (int i = 0; i < 10; i++) cycle(1, 0, 2'b00);          // R5 R7 quad hold
    cycle(1, 0, 2'b01);
    for (int i = 0; i < 10; i++) cycle(1, 1, 2'b11);          // back to dual
    for (int i = 0; i < 2; i++) cycle(0, 0, 2'b11);           // R8 mid-run reset
    for (int i = 0; i < 20; i++) cycle(1, 0, 2'($urandom));
    @(negedge clk);
    compare_all();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule